// File: doc/BRIEF.md
# Variable-length instruction parcel assembler

This block builds one instruction word out of 16-bit parcels read from consecutive byte addresses. A fetch request supplies a byte address. The block reads the parcel at that address first and finds the instruction length from that parcel alone. It then reads each remaining parcel as a separate access with its own address, so that every parcel can go through address translation on its own. When all parcels are in, it presents a 64-bit extended instruction word, a length code and an error code. These stay on the output until the consumer accepts them.

Parcel reads use a simple request/response port. A request (`rd_valid_o`, `rd_addr_o`) is held until `rd_ready_i`. Only one read is outstanding at a time, and its response arrives later on `rsp_valid_i`/`rsp_data_i`. For the upper half of a 4-byte instruction, the block raises a hint that the read falls in the same translated page as the first parcel. The translation stage can then reuse its previous result.

Top module: `parcel_assembler`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `out_valid_o` and `rd_valid_o` are 0.
- R2: The first parcel alone sets the length code on `out_len_o`. If bits[1:0] are not 11, the code is 0 (2 bytes). Otherwise, if bits[4:2] are not 111, the code is 1 (4 bytes). If bits[5:0] are 011111, the code is 2 (6 bytes). If bits[6:0] are 0111111, the code is 3 (8 bytes).
- R3: For a 2-byte instruction, `out_insn_o` is the parcel sign-extended from bit 15 to 64 bits.
- R4: For 4-, 6- and 8-byte instructions, parcel k (k = 0..3) occupies bits [16k+15:16k]. The highest parcel is sign-extended through bit 63, and every lower parcel is zero-extended.
- R5: Parcel reads go out in order at base, base+2, base+4 and base+6. There is one read per parcel and no more reads than the length needs. A read stays asserted with a stable address until `rd_ready_i`.
- R6: `rd_same_page_o` is 1 only on the second read of a 4-byte instruction, and only when the base address's offset within a 4 KiB page (default `PAGE_BITS`=12) is below page size minus 2. It is 0 on every other read.
- R7: A first parcel whose bits[6:0] are 1111111 ends the fetch. `out_err_o` is 2, `out_insn_o` is 0 and `out_len_o` is 0, and no further read is made.
- R8: A request address with bit 0 set gives `out_err_o` = 1, `out_insn_o` = 0 and `out_len_o` = 0, with no parcel read. `out_err_o` is 0 on success.
- R9: The result stays valid and unchanged until `out_ready_i` accepts it.
- R10: A request is accepted only while idle. A request raised during a fetch or while a result is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request |
| req_addr_i | input | ADDR_W | Fetch byte address |
| req_ready_o | output | 1 | Block idle, request accepted |
| rd_valid_o | output | 1 | Parcel read request |
| rd_addr_o | output | ADDR_W | Parcel byte address |
| rd_same_page_o | output | 1 | Read may reuse the first parcel's translation |
| rd_ready_i | input | 1 | Parcel read request taken |
| rsp_valid_i | input | 1 | Parcel data valid |
| rsp_data_i | input | 16 | Parcel data |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result accepted |
| out_insn_o | output | 64 | Extended instruction word |
| out_len_o | output | 2 | Length code: 0=2B, 1=4B, 2=6B, 3=8B |
| out_err_o | output | 2 | 0 none, 1 misaligned, 2 illegal length |

## Verification
The bench sets bit 15 in lower parcels. A design that sign-extended every parcel would then flood the upper bits with ones. It also sets the top bit of the highest parcel, which catches a design that zero-extended everything. Page offsets 0xFFC and 0xFFE sit on both sides of the same-page limit, so an off-by-one comparison shows up as a wrong hint. Length encodings at each boundary, including the illegal all-ones pattern, expose a design that reads too many or too few parcels. A stalled read port, a held result and requests raised while busy expose designs that drop a request, move the address, or start a second fetch too early.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int PARCEL_W    = 16;
  localparam int INSN_W      = 64;
  localparam int MAX_PARCELS = INSN_W / PARCEL_W;
  localparam int IDX_W       = $clog2(MAX_PARCELS);

  typedef enum logic [1:0] {
    LEN_2B = 2'd0,
    LEN_4B = 2'd1,
    LEN_6B = 2'd2,
    LEN_8B = 2'd3
  } len_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_MISALIGN = 2'd1,
    ERR_ILLEGAL  = 2'd2
  } err_e;
endpackage

// File: rtl/pa_len_decode.sv
module pa_len_decode
  import pa_pkg::*;
(
  input  logic [PARCEL_W-1:0] parcel_i,
  output len_e                len_o,
  output logic                illegal_o
);
  always_comb begin
    len_o     = LEN_2B;
    illegal_o = 1'b0;
    if (parcel_i[1:0] != 2'b11)            len_o = LEN_2B;
    else if (parcel_i[4:2] != 3'b111)      len_o = LEN_4B;
    else if (parcel_i[5] == 1'b0)          len_o = LEN_6B;
    else if (parcel_i[6] == 1'b0)          len_o = LEN_8B;
    else                                   illegal_o = 1'b1;
  end
endmodule

// File: rtl/pa_merge.sv
module pa_merge
  import pa_pkg::*;
(
  input  logic [MAX_PARCELS*PARCEL_W-1:0] parcels_i,
  input  len_e                            len_i,
  output logic [INSN_W-1:0]               insn_o
);
  localparam int EXT_W = INSN_W - PARCEL_W;

  logic [INSN_W-1:0] part [MAX_PARCELS];

  for (genvar k = 0; k < MAX_PARCELS; k++) begin : g_part
    logic [PARCEL_W-1:0] p;
    logic [INSN_W-1:0]   ext;
    logic                used, top;
    assign p    = parcels_i[k*PARCEL_W +: PARCEL_W];
    assign used = (IDX_W'(k) <= IDX_W'(len_i));
    assign top  = (IDX_W'(k) == IDX_W'(len_i));
    assign ext  = top ? {{EXT_W{p[PARCEL_W-1]}}, p} : {{EXT_W{1'b0}}, p};
    assign part[k] = used ? (ext << (k*PARCEL_W)) : '0;
  end

  always_comb begin
    insn_o = '0;
    for (int k = 0; k < MAX_PARCELS; k++) insn_o = insn_o | part[k];
  end
endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic [ADDR_W-1:0]               req_addr_i,
  output logic                            req_ready_o,
  output logic                            rd_valid_o,
  output logic [ADDR_W-1:0]               rd_addr_o,
  output logic                            rd_same_page_o,
  input  logic                            rd_ready_i,
  input  logic                            rsp_valid_i,
  input  logic [PARCEL_W-1:0]             rsp_data_i,
  input  len_e                            dec_len_i,
  input  logic                            dec_illegal_i,
  output logic [MAX_PARCELS*PARCEL_W-1:0] parcels_o,
  output len_e                            len_o,
  output err_e                            err_o,
  output logic                            done_o,
  input  logic                            out_ready_i
);
  localparam logic [PAGE_BITS-1:0] OFF_LIMIT = PAGE_BITS'((1 << PAGE_BITS) - 2);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;

  state_e              state_q;
  logic [ADDR_W-1:0]   base_q;
  logic [IDX_W-1:0]    idx_q;
  len_e                len_q;
  err_e                err_q;
  logic [PARCEL_W-1:0] parcel_q [MAX_PARCELS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      len_q   <= LEN_2B;
      err_q   <= ERR_NONE;
      for (int k = 0; k < MAX_PARCELS; k++) parcel_q[k] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          base_q <= req_addr_i;
          idx_q  <= '0;
          len_q  <= LEN_2B;
          for (int k = 0; k < MAX_PARCELS; k++) parcel_q[k] <= '0;
          if (req_addr_i[0]) begin
            err_q   <= ERR_MISALIGN;
            state_q <= ST_DONE;
          end else begin
            err_q   <= ERR_NONE;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (rd_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          parcel_q[idx_q] <= rsp_data_i;
          if (idx_q == '0) begin
            if (dec_illegal_i) begin
              err_q   <= ERR_ILLEGAL;
              state_q <= ST_DONE;
            end else begin
              len_q <= dec_len_i;
              if (dec_len_i == LEN_2B) state_q <= ST_DONE;
              else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_ISSUE;
              end
            end
          end else if (idx_q == IDX_W'(len_q)) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign rd_valid_o     = (state_q == ST_ISSUE);
  assign rd_addr_o      = base_q + ADDR_W'({idx_q, 1'b0});
  assign rd_same_page_o = rd_valid_o && (idx_q == IDX_W'(1)) && (len_q == LEN_4B)
                          && (base_q[PAGE_BITS-1:0] < OFF_LIMIT);
  assign done_o         = (state_q == ST_DONE);
  assign len_o          = len_q;
  assign err_o          = err_q;

  for (genvar k = 0; k < MAX_PARCELS; k++) begin : g_pack
    assign parcels_o[k*PARCEL_W +: PARCEL_W] = parcel_q[k];
  end

  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  // R6
  same_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_same_page_o |-> rd_valid_o && rd_addr_o[0] == 1'b0);
  // R8
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && req_addr_i[0] |=> done_o && err_o == ERR_MISALIGN);
endmodule

// File: rtl/parcel_assembler.sv
module parcel_assembler
  import pa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_same_page_o,
  input  logic              rd_ready_i,
  input  logic              rsp_valid_i,
  input  logic [15:0]       rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [63:0]       out_insn_o,
  output logic [1:0]        out_len_o,
  output logic [1:0]        out_err_o
);
  len_e                            dec_len, len_q;
  logic                            dec_illegal;
  err_e                            err_q;
  logic [MAX_PARCELS*PARCEL_W-1:0] parcels;
  logic [INSN_W-1:0]               merged;
  logic                            done;

  pa_len_decode u_dec (
    .parcel_i (rsp_data_i),
    .len_o    (dec_len),
    .illegal_o(dec_illegal)
  );

  pa_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_addr_i, .req_ready_o,
    .rd_valid_o, .rd_addr_o, .rd_same_page_o, .rd_ready_i,
    .rsp_valid_i, .rsp_data_i,
    .dec_len_i    (dec_len),
    .dec_illegal_i(dec_illegal),
    .parcels_o    (parcels),
    .len_o        (len_q),
    .err_o        (err_q),
    .done_o       (done),
    .out_ready_i
  );

  pa_merge u_merge (
    .parcels_i(parcels),
    .len_i    (len_q),
    .insn_o   (merged)
  );

  assign out_valid_o = done;
  assign out_err_o   = err_q;
  assign out_len_o   = (err_q == ERR_NONE) ? len_q : LEN_2B;
  assign out_insn_o  = (err_q == ERR_NONE) ? merged : '0;

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_insn_o) && $stable(out_err_o));
  // R3
  short_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_err_o == 2'd0 && out_len_o == 2'd0 |-> out_insn_o[63:16] == {48{out_insn_o[15]}});
  // R10
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !rd_valid_o && !req_ready_o);
  // R7
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_err_o != 2'd0 |-> out_insn_o == '0);
endmodule

// File: tb/parcel_assembler_test.sv
`timescale 1ns/1ps
module parcel_assembler_test;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, rd_ready = 0, rsp_valid = 0, out_ready = 0;
  logic [31:0] req_addr = '0;
  logic [15:0] rsp_data = '0;
  logic        req_ready, rd_valid, rd_same_page, out_valid;
  logic [31:0] rd_addr;
  logic [63:0] out_insn;
  logic [1:0]  out_len, out_err;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  parcel_assembler uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_same_page_o(rd_same_page),
    .rd_ready_i(rd_ready), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_insn_o(out_insn), .out_len_o(out_len), .out_err_o(out_err)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [63:0] parcels;  // p3,p2,p1,p0
    logic [63:0] insn;
    logic [1:0]  len;
    logic [1:0]  err;
    logic [2:0]  reads;
    logic        same_page;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0100, 64'h0000_0000_0000_8001, 64'hFFFF_FFFF_FFFF_8001, 2'd0, 2'd0, 3'd1, 1'b0},
    '{32'h0000_0202, 64'h0000_0000_0000_7FFC, 64'h0000_0000_0000_7FFC, 2'd0, 2'd0, 3'd1, 1'b0},
    '{32'h0000_1000, 64'h0000_0000_8000_0013, 64'hFFFF_FFFF_8000_0013, 2'd1, 2'd0, 3'd2, 1'b1},
    '{32'h0000_1FFE, 64'h0000_0000_1234_ABC3, 64'h0000_0000_1234_ABC3, 2'd1, 2'd0, 3'd2, 1'b0},
    '{32'h0000_1FFC, 64'h0000_0000_0001_FFF3, 64'h0000_0000_0001_FFF3, 2'd1, 2'd0, 3'd2, 1'b1},
    '{32'h0000_3000, 64'h0000_8000_FFFF_801F, 64'hFFFF_8000_FFFF_801F, 2'd2, 2'd0, 3'd3, 1'b0},
    '{32'h0000_3FFC, 64'h0000_7123_0000_001F, 64'h0000_7123_0000_001F, 2'd2, 2'd0, 3'd3, 1'b0},
    '{32'h0000_4000, 64'hFEDC_9999_8888_C03F, 64'hFEDC_9999_8888_C03F, 2'd3, 2'd0, 3'd4, 1'b0},
    '{32'h0000_4FFA, 64'h0001_2222_1111_003F, 64'h0001_2222_1111_003F, 2'd3, 2'd0, 3'd4, 1'b0},
    '{32'h0000_5000, 64'h1111_2222_3333_007F, 64'h0000_0000_0000_0000, 2'd0, 2'd2, 3'd1, 1'b0},
    '{32'h0000_5002, 64'h1111_2222_3333_FFFF, 64'h0000_0000_0000_0000, 2'd0, 2'd2, 3'd1, 1'b0},
    '{32'h0000_0101, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_0000, 2'd0, 2'd1, 3'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one fetch; leaves result held (not accepted) at a negedge.
  task automatic fetch(input vec_t v, input int stall);
    int n = 0, cyc = 0;
    @(negedge clk);
    chk(req_ready, "R10 idle before request", 64'(req_ready), 64'd1);
    req_valid = 1; req_addr = v.addr;
    @(negedge clk);
    req_valid = 0;
    while (!out_valid && cyc < 40) begin
      if (rd_valid) begin
        chk(rd_addr == v.addr + 32'(2*n), "R5 read address", 64'(rd_addr), 64'(v.addr + 32'(2*n)));
        chk(rd_same_page == (n == 1 && v.same_page), "R6 same-page hint",
            64'(rd_same_page), 64'(n == 1 && v.same_page));
        if (n == 0) for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(rd_valid && rd_addr == v.addr, "R5 read held while stalled", 64'(rd_addr), 64'(v.addr));
        end
        rd_ready = 1;
        @(negedge clk);
        rd_ready = 0; rsp_valid = 1; rsp_data = v.parcels[16*(n%4) +: 16];
        @(negedge clk);
        rsp_valid = 0;
        n++;
      end else @(negedge clk);
      cyc++;
    end
    chk(out_valid, "R9 result valid", 64'(out_valid), 64'd1);
    chk(n == int'(v.reads), "R5 R7 R8 read count", 64'(n), 64'(v.reads));
    chk(out_insn == v.insn, "R3 R4 R7 instruction word", out_insn, v.insn);
    chk(out_len == v.len, "R2 length code", 64'(out_len), 64'(v.len));
    chk(out_err == v.err, "R7 R8 error code", 64'(out_err), 64'(v.err));
  endtask

  task automatic accept();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid && req_ready, "R9 released after accept", 64'(out_valid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !out_valid && !rd_valid, "R1 reset state",
        {61'd0, req_ready, out_valid, rd_valid}, 64'd4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !out_valid && !rd_valid, "R1 idle after reset",
        {61'd0, req_ready, out_valid, rd_valid}, 64'd4);

    for (int i = 0; i < NV; i++) begin
      fetch(VEC[i], 0);
      accept();
    end

    // R5: stalled read port on an 8-byte fetch
    fetch(VEC[7], 3);
    // R9 R10: held result, requests raised while busy are ignored
    req_valid = 1; req_addr = 32'h0000_0800;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(out_valid && out_insn == VEC[7].insn && !req_ready, "R9 R10 result held",
          out_insn, VEC[7].insn);
    end
    req_valid = 0;
    accept();
    @(negedge clk);
    chk(!rd_valid && req_ready, "R10 busy request had no effect", 64'(rd_valid), 64'd0);

    // R10: request during parcel fetch ignored
    @(negedge clk);
    req_valid = 1; req_addr = VEC[2].addr;
    @(negedge clk);
    req_addr = 32'h0000_0901;  // keep req_valid high while fetching
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0; rsp_valid = 1; rsp_data = VEC[2].parcels[15:0];
    @(negedge clk);
    rsp_valid = 0;
    chk(rd_valid && rd_addr == VEC[2].addr + 32'd2, "R10 mid-fetch request ignored",
        64'(rd_addr), 64'(VEC[2].addr + 32'd2));
    req_valid = 0;
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0; rsp_valid = 1; rsp_data = VEC[2].parcels[31:16];
    @(negedge clk);
    rsp_valid = 0;
    chk(out_valid && out_insn == VEC[2].insn && out_err == 2'd0, "R4 R10 fetch completed intact",
        out_insn, VEC[2].insn);
    accept();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule